// File: doc/BRIEF.md
# Permissioned Set-Associative Tag Directory

This block holds the tags, access permissions, reservation locks and replacement order of a set-associative cache. It stores no data. A controller sends one line-aligned address per request on a single port, together with an operation code. The block answers with a result one cycle later. Depending on the operation, the result is a grant flag, a way number, a victim address or a lock test outcome.

Each resident line carries a three-bit permission. A lookup is granted when the tag matches and the permission allows the access type. A line can also hold a reservation taken by a four-bit context identifier. Replacement is true least-recently-used within each set. Recency changes when a lookup hits a resident tag, and when an allocation asks for it. Ways that are empty, or that are marked not-present, can be reused by allocation. The lowest-numbered such way is chosen first.

Top module: `tag_dir`

## Requirements
- R1: The set count is TOTAL_BYTES / (WAYS * LINE_BYTES), which must be at least 2. The set index is req_addr[SET_LSB +: log2(sets)]. Lines whose index bits differ never compete for the same ways.
- R2: A request accepted with req_valid produces exactly one response with rsp_valid high on the next cycle. No response appears without a request, and rsp_valid is low during and after reset.
- R3: Access types are load=0, ifetch=1, store=2, atomic=3. Permissions are not-present=0, invalid=1, read-only=2, read-write=3, busy=4. A lookup (op 0) is granted (rsp_hit=1) when the matching line is read-write for any access type, or read-only for a load or ifetch. Every other case is denied. rsp_way gives the matching way.
- R4: A tag match on a way whose permission is not-present counts as a miss. It does not change recency.
- R5: A lookup that matches a resident line (permission not 0) makes that way most recent, whether or not access is granted.
- R6: The availability check (op 1) returns rsp_hit=1 if the address is stored in its set, or if any way of the set is empty or not-present.
- R7: Allocate (op 2) fills the lowest-numbered empty or not-present way and returns that way. The new line gets permission invalid and no lock. Recency is updated only when req_touch=1.
- R8: Allocate with no empty or not-present way, or for an address already resident, returns rsp_err=1 and rsp_hit=0. It changes nothing.
- R9: The victim probe (op 4) returns in rsp_addr the stored address of the least-recently-used way of the set, and that way in rsp_way.
- R10: Lock (op 6) records req_ctx on a resident line and unlock (op 7) releases it. Lock test (op 8) returns rsp_hit=1 only while the line is locked by the same req_ctx.
- R11: Lock, unlock, lock test and set-permission requests for a non-resident address return rsp_err=1 and change nothing.
- R12: Deallocate (op 3) empties the way holding a resident address and returns rsp_hit=1. For a non-resident address it returns rsp_hit=0, rsp_err=0 and has no effect.
- R13: Set-permission (op 5) writes req_perm into a resident line and returns rsp_hit=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line-aligned address |
| req_acc | input | 2 | Access type for lookups |
| req_perm | input | 3 | Permission for set-permission |
| req_ctx | input | CTX_W | Context identifier for lock operations |
| req_touch | input | 1 | Allocate also updates recency |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Grant, success or test result |
| rsp_way | output | log2(WAYS) | Way involved in the operation |
| rsp_addr | output | ADDR_W | Victim address for probes |
| rsp_err | output | 1 | Illegal request, state unchanged |

## Verification
Every result of this block is due on the first rising edge after the request is sampled. This holds for grant, availability, allocation way, victim address, lock test and error. The bench drives requests on the falling edge and queues the expected result at the same moment. A monitor on each later falling edge pops the oldest entry whenever rsp_valid is high. A response with nothing queued, or a queue left non-empty after an idle cycle, shows a broken one-cycle timing. Recency effects are observed through later victim probes rather than internal state.

// File: rtl/tag_dir_pkg.sv
// Package: encodings shared by the tag directory modules.
// Assumes op, permission and access codes fixed independently of parameters.
package tag_dir_pkg;

    typedef enum logic [3:0] {
        OP_LOOKUP   = 4'd0,
        OP_AVAIL    = 4'd1,
        OP_ALLOC    = 4'd2,
        OP_DEALLOC  = 4'd3,
        OP_PROBE    = 4'd4,
        OP_SETPERM  = 4'd5,
        OP_LOCK     = 4'd6,
        OP_UNLOCK   = 4'd7,
        OP_LOCKTEST = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        PERM_NP   = 3'd0,
        PERM_INV  = 3'd1,
        PERM_RO   = 3'd2,
        PERM_RW   = 3'd3,
        PERM_BUSY = 3'd4
    } perm_e;

    typedef enum logic [1:0] {
        ACC_LOAD   = 2'd0,
        ACC_IFETCH = 2'd1,
        ACC_STORE  = 2'd2,
        ACC_ATOMIC = 2'd3
    } acc_e;

    // Decide whether a line permission allows an access type.
    function automatic logic perm_grants(input logic [2:0] perm, input logic [1:0] acc);
        logic ok;
        case (perm)
            PERM_RW: ok = 1'b1;
            PERM_RO: ok = (acc == ACC_LOAD) || (acc == ACC_IFETCH);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tag_dir_match.sv
// Module: tag_dir_match
// Compares one set's ways against a request address and finds free ways.
// Assumes at most one resident way per address (kept by the allocator).
// Purely combinational.
module tag_dir_match
    import tag_dir_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int ADDR_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             way_valid,
    input  logic [WAYS-1:0][ADDR_W-1:0] way_addr,
    input  logic [WAYS-1:0][2:0]        way_perm,
    input  logic [ADDR_W-1:0]           probe_addr,
    output logic                        res_hit,
    output logic [WAY_W-1:0]            res_way,
    output logic                        tag_seen,
    output logic                        free_any,
    output logic [WAY_W-1:0]            free_way
);

    logic [WAYS-1:0] seen_vec;
    logic [WAYS-1:0] res_vec;
    logic [WAYS-1:0] free_vec;

    // Per-way compare: stored tag, resident tag, reusable slot.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign seen_vec[w] = way_valid[w] && (way_addr[w] == probe_addr);
        assign res_vec[w]  = seen_vec[w] && (way_perm[w] != PERM_NP);
        assign free_vec[w] = !way_valid[w] || (way_perm[w] == PERM_NP);
    end

    assign res_hit  = |res_vec;
    assign tag_seen = |seen_vec;
    assign free_any = |free_vec;

    // Encode the resident way and the lowest-numbered free way.
    always_comb begin
        res_way  = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (res_vec[w])  res_way  = WAY_W'(w);
            if (free_vec[w]) free_way = WAY_W'(w);
        end
    end

endmodule

// File: rtl/tag_dir_lru.sv
// Module: tag_dir_lru
// True LRU order per set, kept as one age per way (0 = most recent).
// Assumes WAYS is a power of two so ages 0..WAYS-1 fill WAY_W bits exactly.
// Reset gives way w the age w, so the highest way is the first victim.
module tag_dir_lru #(
    parameter int SETS = 4,
    parameter int WAYS = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic [WAY_W-1:0] touch_way,
    input  logic [SET_W-1:0] query_set,
    output logic [WAY_W-1:0] victim_way
);

    localparam logic [WAY_W-1:0] OLDEST = WAY_W'(WAYS - 1);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAYS-1:0]  victim_vec;

    // Age update: touched way becomes 0, younger ways grow older by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[touch_set][w] <= '0;
                else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
                    age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
            end
        end
    end

    // Victim selection: the way holding the oldest age in the queried set.
    always_comb begin
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            victim_vec[w] = (age_q[query_set][w] == OLDEST);
            if (victim_vec[w]) victim_way = WAY_W'(w);
        end
    end

    // A touched way must read as most recent on the next cycle.
    assert_touch_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (age_q[$past(touch_set)][$past(touch_way)] == '0));

    // The ages of a set stay a permutation: exactly one oldest way.
    assert_single_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(victim_vec) == 1);

endmodule

// File: rtl/tag_dir.sv
// Module: tag_dir (top)
// Tag, permission, lock and LRU store of a set-associative cache.
// Assumes line-aligned request addresses and a power-of-two way count.
// Every request is answered through registered outputs one cycle later.
module tag_dir
    import tag_dir_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int TOTAL_BYTES = 1024,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 64,
    parameter int SET_LSB     = 6,
    parameter int CTX_W       = 4,
    localparam int SETS  = TOTAL_BYTES / (WAYS * LINE_BYTES),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [3:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_acc,
    input  logic [2:0]        req_perm,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_touch,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_err
);

    // Stored per-line state, one row per set.
    logic [WAYS-1:0]             line_v_q    [SETS];
    logic [WAYS-1:0][ADDR_W-1:0] line_addr_q [SETS];
    logic [WAYS-1:0][2:0]        line_perm_q [SETS];
    logic [WAYS-1:0]             lock_v_q    [SETS];
    logic [WAYS-1:0][CTX_W-1:0]  lock_id_q   [SETS];

    logic [SET_W-1:0] set_idx;
    op_e              op;
    logic             res_hit, tag_seen, free_any;
    logic [WAY_W-1:0] res_way, free_way, victim_way;
    logic             touch_en;
    logic [WAY_W-1:0] touch_way;
    logic             wr_fill, wr_drop, wr_perm, wr_lock, wr_unlock;
    logic             d_hit, d_err;
    logic [WAY_W-1:0] d_way;
    logic [ADDR_W-1:0] d_addr;
    logic [2:0]       cur_perm;
    logic             cur_lock_v;
    logic [CTX_W-1:0] cur_lock_id;

    // Kept for the checks only: which request a response belongs to.
    logic [3:0]       rsp_op_q;
    logic [SET_W-1:0] rsp_set_q;
    logic [CTX_W-1:0] rsp_ctx_q;

    assign set_idx     = req_addr[SET_LSB +: SET_W];
    assign op          = op_e'(req_op);
    assign cur_perm    = line_perm_q[set_idx][res_way];
    assign cur_lock_v  = lock_v_q[set_idx][res_way];
    assign cur_lock_id = lock_id_q[set_idx][res_way];

    tag_dir_match #(
        .WAYS   (WAYS),
        .ADDR_W (ADDR_W)
    ) u_match (
        .way_valid  (line_v_q[set_idx]),
        .way_addr   (line_addr_q[set_idx]),
        .way_perm   (line_perm_q[set_idx]),
        .probe_addr (req_addr),
        .res_hit    (res_hit),
        .res_way    (res_way),
        .tag_seen   (tag_seen),
        .free_any   (free_any),
        .free_way   (free_way)
    );

    tag_dir_lru #(
        .SETS (SETS),
        .WAYS (WAYS)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_set  (set_idx),
        .touch_way  (touch_way),
        .query_set  (set_idx),
        .victim_way (victim_way)
    );

    // Operation decode: pick state writes, recency touch and response.
    always_comb begin
        touch_en  = 1'b0;
        touch_way = res_way;
        wr_fill   = 1'b0;
        wr_drop   = 1'b0;
        wr_perm   = 1'b0;
        wr_lock   = 1'b0;
        wr_unlock = 1'b0;
        d_hit     = 1'b0;
        d_err     = 1'b0;
        d_way     = '0;
        d_addr    = '0;
        if (req_valid) begin
            case (op)
                OP_LOOKUP: begin
                    d_way = res_way;
                    if (res_hit) begin
                        touch_en = 1'b1;
                        d_hit    = perm_grants(cur_perm, req_acc);
                    end
                end
                OP_AVAIL: d_hit = tag_seen | free_any;
                OP_ALLOC: begin
                    if (!free_any || res_hit) begin
                        d_err = 1'b1;
                    end else begin
                        wr_fill   = 1'b1;
                        d_hit     = 1'b1;
                        d_way     = free_way;
                        touch_en  = req_touch;
                        touch_way = free_way;
                    end
                end
                OP_DEALLOC: begin
                    if (res_hit) begin
                        wr_drop = 1'b1;
                        d_hit   = 1'b1;
                        d_way   = res_way;
                    end
                end
                OP_PROBE: begin
                    d_hit  = 1'b1;
                    d_way  = victim_way;
                    d_addr = line_addr_q[set_idx][victim_way];
                end
                OP_SETPERM, OP_LOCK, OP_UNLOCK, OP_LOCKTEST: begin
                    if (!res_hit) begin
                        d_err = 1'b1;
                    end else begin
                        d_way = res_way;
                        case (op)
                            OP_SETPERM: begin wr_perm   = 1'b1; d_hit = 1'b1; end
                            OP_LOCK:    begin wr_lock   = 1'b1; d_hit = 1'b1; end
                            OP_UNLOCK:  begin wr_unlock = 1'b1; d_hit = 1'b1; end
                            default:    d_hit = cur_lock_v && (cur_lock_id == req_ctx);
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    // Line state update: fill, drop, permission and lock writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                line_v_q[s]    <= '0;
                line_addr_q[s] <= '0;
                line_perm_q[s] <= '0;
                lock_v_q[s]    <= '0;
                lock_id_q[s]   <= '0;
            end
        end else begin
            if (wr_fill) begin
                line_v_q[set_idx][free_way]    <= 1'b1;
                line_addr_q[set_idx][free_way] <= req_addr;
                line_perm_q[set_idx][free_way] <= PERM_INV;
                lock_v_q[set_idx][free_way]    <= 1'b0;
            end
            if (wr_drop) begin
                line_v_q[set_idx][res_way] <= 1'b0;
                lock_v_q[set_idx][res_way] <= 1'b0;
            end
            if (wr_perm)
                line_perm_q[set_idx][res_way] <= req_perm;
            if (wr_lock) begin
                lock_v_q[set_idx][res_way]  <= 1'b1;
                lock_id_q[set_idx][res_way] <= req_ctx;
            end
            if (wr_unlock)
                lock_v_q[set_idx][res_way] <= 1'b0;
        end
    end

    // Response registers: results are presented one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_way   <= '0;
            rsp_addr  <= '0;
            rsp_err   <= 1'b0;
            rsp_op_q  <= '0;
            rsp_set_q <= '0;
            rsp_ctx_q <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= d_hit;
            rsp_way   <= d_way;
            rsp_addr  <= d_addr;
            rsp_err   <= d_err;
            rsp_op_q  <= req_op;
            rsp_set_q <= set_idx;
            rsp_ctx_q <= req_ctx;
        end
    end

    // Response timing: one response per request, on the next cycle only.
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // An error response never also reports success.
    assert_err_not_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_hit);

    // A filled way is valid, invalid-permission and unlocked afterwards.
    assert_fill_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fill |=> (line_v_q[$past(set_idx)][$past(free_way)]
                     && line_perm_q[$past(set_idx)][$past(free_way)] == PERM_INV
                     && !lock_v_q[$past(set_idx)][$past(free_way)]));

    // A positive lock test means the reported way is held by that context.
    assert_locktest_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op_q == OP_LOCKTEST && rsp_hit)
            |-> (lock_v_q[rsp_set_q][rsp_way] && lock_id_q[rsp_set_q][rsp_way] == rsp_ctx_q));

endmodule

// File: tb/tag_dir_tb.sv
`timescale 1ns/1ps
module tag_dir_tb;

    typedef struct {
        logic        hit;
        logic        err;
        int          way;
        logic        chk_addr;
        logic [31:0] addr;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [3:0]  req_op;
    logic [31:0] req_addr;
    logic [1:0]  req_acc;
    logic [2:0]  req_perm;
    logic [3:0]  req_ctx;
    logic        req_touch;
    logic        rsp_valid, rsp_hit, rsp_err;
    logic [1:0]  rsp_way;
    logic [31:0] rsp_addr;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;

    always #10 clk = ~clk;

    tag_dir u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_op (req_op),
        .req_addr (req_addr), .req_acc (req_acc), .req_perm (req_perm),
        .req_ctx (req_ctx), .req_touch (req_touch), .rsp_valid (rsp_valid),
        .rsp_hit (rsp_hit), .rsp_way (rsp_way), .rsp_addr (rsp_addr), .rsp_err (rsp_err)
    );

    function automatic logic [31:0] mk(input int t, input int s);
        return (32'(t) << 8) | (32'(s) << 6);
    endfunction

    // Driver: present one request and queue its expected result.
    task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [1:0] acc,
                         input logic [2:0] perm, input logic [3:0] ctx, input logic touch,
                         input logic ehit, input logic eerr, input int eway,
                         input logic chka, input logic [31:0] eaddr, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_acc = acc;
        req_perm = perm; req_ctx = ctx; req_touch = touch;
        e.hit = ehit; e.err = eerr; e.way = eway; e.chk_addr = chka; e.addr = eaddr; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic lk(input logic [31:0] a, input logic [1:0] acc, input logic ehit, input int eway, input string tag);
        issue(4'd0, a, acc, 3'd0, 4'd0, 1'b0, ehit, 1'b0, eway, 1'b0, 32'd0, tag);
    endtask
    task automatic avail(input logic [31:0] a, input logic ehit, input string tag);
        issue(4'd1, a, 2'd0, 3'd0, 4'd0, 1'b0, ehit, 1'b0, -1, 1'b0, 32'd0, tag);
    endtask
    task automatic alloc(input logic [31:0] a, input logic touch, input logic eerr, input int eway, input string tag);
        issue(4'd2, a, 2'd0, 3'd0, 4'd0, touch, !eerr, eerr, eway, 1'b0, 32'd0, tag);
    endtask
    task automatic dealloc(input logic [31:0] a, input logic ehit, input string tag);
        issue(4'd3, a, 2'd0, 3'd0, 4'd0, 1'b0, ehit, 1'b0, -1, 1'b0, 32'd0, tag);
    endtask
    task automatic probe(input logic [31:0] a, input int eway, input logic [31:0] eaddr, input string tag);
        issue(4'd4, a, 2'd0, 3'd0, 4'd0, 1'b0, 1'b1, 1'b0, eway, 1'b1, eaddr, tag);
    endtask
    task automatic setperm(input logic [31:0] a, input logic [2:0] p, input logic eerr, input string tag);
        issue(4'd5, a, 2'd0, p, 4'd0, 1'b0, !eerr, eerr, -1, 1'b0, 32'd0, tag);
    endtask
    task automatic lockop(input logic [3:0] op, input logic [31:0] a, input logic [3:0] ctx,
                          input logic ehit, input logic eerr, input string tag);
        issue(op, a, 2'd0, 3'd0, ctx, 1'b0, ehit, eerr, -1, 1'b0, 32'd0, tag);
    endtask

    // Monitor: compare every response against the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R2 unexpected response: rsp_valid=1 expected 0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_err !== e.err
                    || (e.way >= 0 && int'(rsp_way) != e.way)
                    || (e.chk_addr && rsp_addr !== e.addr)) begin
                    fails++;
                    $display("FAIL %s: hit=%0b err=%0b way=%0d addr=%h expected hit=%0b err=%0b way=%0d addr=%h",
                             e.tag, rsp_hit, rsp_err, rsp_way, rsp_addr, e.hit, e.err, e.way, e.addr);
                end
            end
        end
    end

    task automatic check(input bit cond, input string msg);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s", msg);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired: done=0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] a0, b0, c0, d0, e0, f0;
        a0 = mk(1, 0); b0 = mk(2, 0); c0 = mk(3, 0);
        d0 = mk(4, 0); e0 = mk(5, 0); f0 = mk(6, 0);
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_acc = '0; req_perm = '0; req_ctx = '0; req_touch = 1'b0;
        repeat (3) @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_err === 1'b0,
              $sformatf("R2 reset state: rsp_valid=%0b rsp_err=%0b expected 0 0", rsp_valid, rsp_err));
        rst_n = 1'b1;

        // R3/R4: empty set misses; R6 empty set is available.
        lk(a0, 2'd0, 1'b0, -1, "R3 lookup in empty set");
        avail(a0, 1'b1, "R6 empty set available");
        // R7: fill without touch lands in way 0 as invalid.
        alloc(a0, 1'b0, 1'b0, 0, "R7 first fill way 0");
        lk(a0, 2'd0, 1'b0, 0, "R3 invalid line denies load");
        // R13 + R3: permission changes drive grant decisions.
        setperm(a0, 3'd2, 1'b0, "R13 set read-only");
        lk(a0, 2'd0, 1'b1, 0, "R3 read-only grants load");
        lk(a0, 2'd1, 1'b1, 0, "R3 read-only grants ifetch");
        lk(a0, 2'd2, 1'b0, 0, "R3 read-only denies store");
        setperm(a0, 3'd3, 1'b0, "R13 set read-write");
        lk(a0, 2'd2, 1'b1, 0, "R3 read-write grants store");
        lk(a0, 2'd3, 1'b1, 0, "R3 read-write grants atomic");
        setperm(a0, 3'd4, 1'b0, "R13 set busy");
        lk(a0, 2'd0, 1'b0, 0, "R3 busy denies load");
        // R7: remaining fills take ways in ascending order.
        alloc(b0, 1'b0, 1'b0, 1, "R7 second fill way 1");
        alloc(c0, 1'b0, 1'b0, 2, "R7 third fill way 2");
        alloc(d0, 1'b0, 1'b0, 3, "R7 fourth fill way 3");
        avail(e0, 1'b0, "R6 full set unavailable for new tag");
        avail(b0, 1'b1, "R6 full set available for stored tag");
        alloc(e0, 1'b0, 1'b1, -1, "R8 fill with no free way");
        alloc(b0, 1'b0, 1'b1, -1, "R8 fill of resident address");
        // R9 + R7: untouched fills leave reset order, victim is way 3.
        probe(e0, 3, d0, "R9 victim after untouched fills");
        // R5: a denied lookup still makes way 3 most recent.
        lk(d0, 2'd0, 1'b0, 3, "R5 denied lookup on invalid line");
        probe(e0, 2, c0, "R5 victim moves after denied lookup");
        // R12: deallocate and repeat deallocate.
        dealloc(c0, 1'b1, "R12 deallocate resident");
        lk(c0, 2'd0, 1'b0, -1, "R12 removed line misses");
        dealloc(c0, 1'b0, "R12 deallocate absent has no effect");
        avail(e0, 1'b1, "R6 freed way makes set available");
        // R7: fill with touch takes way 2 and makes it most recent.
        alloc(e0, 1'b1, 1'b0, 2, "R7 touched fill reuses way 2");
        probe(e0, 1, b0, "R7 touch moved victim to way 1");
        // R4: not-present line misses and does not touch recency.
        setperm(b0, 3'd0, 1'b0, "R13 set not-present");
        lk(b0, 2'd0, 1'b0, -1, "R4 not-present tag misses");
        probe(e0, 1, b0, "R4 not-present lookup leaves victim");
        avail(f0, 1'b1, "R6 not-present way counts as free");
        alloc(f0, 1'b0, 1'b0, 1, "R7 fill reuses not-present way");
        probe(f0, 1, f0, "R9 victim reports new stored address");
        setperm(b0, 3'd3, 1'b1, "R11 set permission on absent line");
        // R1: other index bits select an independent set.
        avail(mk(5, 1), 1'b1, "R1 other set still available");
        alloc(mk(5, 1), 1'b0, 1'b0, 0, "R1 other set fills from way 0");
        lk(mk(1, 1), 2'd0, 1'b0, -1, "R1 same tag other set misses");
        // R10: lock ownership.
        lockop(4'd6, a0, 4'd5, 1'b1, 1'b0, "R10 lock by context 5");
        lockop(4'd8, a0, 4'd5, 1'b1, 1'b0, "R10 test by owner");
        lockop(4'd8, a0, 4'd6, 1'b0, 1'b0, "R10 test by other context");
        lockop(4'd7, a0, 4'd0, 1'b1, 1'b0, "R10 unlock");
        lockop(4'd8, a0, 4'd5, 1'b0, 1'b0, "R10 test after unlock");
        // R7: a fresh fill carries no lock.
        lockop(4'd6, e0, 4'd3, 1'b1, 1'b0, "R10 lock line in way 2");
        dealloc(e0, 1'b1, "R12 drop locked line");
        alloc(e0, 1'b0, 1'b0, 2, "R7 refill way 2");
        lockop(4'd8, e0, 4'd3, 1'b0, 1'b0, "R7 refilled line unlocked");
        // R11: lock operations on absent lines.
        lockop(4'd6, mk(9, 3), 4'd2, 1'b0, 1'b1, "R11 lock absent line");
        lockop(4'd8, mk(9, 3), 4'd2, 1'b0, 1'b1, "R11 test absent line");
        lockop(4'd7, mk(9, 3), 4'd2, 1'b0, 1'b1, "R11 unlock absent line");
        lk(mk(9, 3), 2'd0, 1'b0, -1, "R11 absent line still absent");
        avail(mk(9, 3), 1'b1, "R11 set 3 still empty");
        idle();
        @(negedge clk);
        check(rsp_valid === 1'b0, $sformatf("R2 no response when idle: rsp_valid=%0b expected 0", rsp_valid));
        check(exp_q.size() == 0, $sformatf("R2 responses outstanding: %0d expected 0", exp_q.size()));
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule